// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 21 interrupt request lines and turns them into two processor request outputs: a normal request and a fast request. Software programs it through a small word-addressed register space. Each source carries a 3-bit priority. The first eight sources can each be set to level, rising-edge or falling-edge sensing. For each of the two paths, the block picks the most urgent pending enabled source and presents a handler address. That address is formed from a programmable table base plus four bytes per source index.

Nesting is tracked separately for each path with an in-service set of priority levels. A handler claims its level by reading the vector register of its path. It releases the level by writing the in-service register of that path. When nesting is turned on for a path, only a request of strictly higher priority than the highest level in service reaches the output.

Byte offsets in the normal bank are as follows:
- 0x00: active sources (read only)
- 0x04: raw source levels (read only)
- 0x08: enable-set (reads back the enable mask)
- 0x0C: enable-clear (write only)
- 0x10: vector (read only)
- 0x14: table base
- 0x18: in-service level
- 0x20, 0x24, 0x28: priority words
- 0x30: nesting control
- 0x34: trigger configuration
- 0x38: edge-clear (write only)

The fast bank repeats offsets 0x00 to 0x18 at 0x100 and up, except the table base, which both paths share. Unmapped reads return zero.

Top module: `irqc_top`

## Requirements
- R1: After reset, every writable register reads zero, the in-service register reads zero, and both irq_o and fiq_o are low.
- R2: The raw register, at offset 0x04 or 0x104, shows src_i for every source whatever its enable state. Bit i is source i.
- R3: Writing to the enable-set register sets the enable bits written as 1. Writing to the enable-clear register clears the bits written as 1. All other enable bits keep their values. Each path has its own pair of registers.
- R4: The active register reads pending AND enable for its path. With nesting off, irq_o is high exactly when the normal active register is non-zero.
- R5: The winner is the pending enabled source with the numerically largest priority, where 7 is the most urgent. On a tie the lower source index wins. The vector register reads base + 4*index of the winner, or the base alone when nothing is active. Base bits [1:0] always read zero.
- R6: Priorities sit in three words at 0x20, 0x24 and 0x28. Source i occupies bits [4*(i%8)+2 : 4*(i%8)] of word i/8. The other bits read zero.
- R7: The trigger word gives source i (i < 8) a 2-bit code at bits [2i+1:2i]: 00 or 11 for level, 01 for rising edge, 10 for falling edge. A level source is pending while its input is high. An edge source latches pending on the selected transition and stays pending after the input returns. The capture adds one cycle of delay.
- R8: Writing 1 to bit i of the edge-clear register clears the latched edge of source i. A held level does not set the latch again.
- R9: Reading a path's vector register while a winner exists puts the winner's priority into service. The in-service register reads {busy at bit 3, highest level in service at bits 2:0}. Writing the in-service register releases the highest level. Nesting control bit 0 (normal) or bit 1 (fast) masks the request output unless the winner's priority is strictly above the highest level in service. With the bit clear, the level is ignored.
- R10: The fast path uses its own enable, active, vector and in-service registers at +0x100, drives fiq_o, and works independently of the normal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 21 | Interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (vector reads have a side effect) |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe are never given in the same cycle. They also assume that a vector read and an in-service release never coincide on one path, which is what a handler sequence produces. The bench drives one bus operation at a time through tasks that raise exactly one strobe for one cycle. It changes src_i only away from bus traffic, so every claim and release is a single, isolated event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BUS_W = 32;

  localparam logic [7:0] OFS_ACT   = 8'h00;
  localparam logic [7:0] OFS_RAW   = 8'h04;
  localparam logic [7:0] OFS_ENSET = 8'h08;
  localparam logic [7:0] OFS_ENCLR = 8'h0C;
  localparam logic [7:0] OFS_VEC   = 8'h10;
  localparam logic [7:0] OFS_BASE  = 8'h14;
  localparam logic [7:0] OFS_LVL   = 8'h18;
  localparam logic [7:0] OFS_PRIO  = 8'h20;
  localparam logic [7:0] OFS_NEST  = 8'h30;
  localparam logic [7:0] OFS_TRIG  = 8'h34;
  localparam logic [7:0] OFS_ECLR  = 8'h38;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_LVL2  = 2'b11
  } trig_e;

  // handler pointer: one 32-bit entry per source
  function automatic logic [BUS_W-1:0] vec_addr(input logic [BUS_W-1:0] base,
                                                input logic [7:0] idx);
    return base + {22'd0, idx, 2'b00};
  endfunction

  // byte offset of the priority word holding source i
  function automatic logic [7:0] prio_word_ofs(input int i);
    return OFS_PRIO + 8'(4 * (i / 8));
  endfunction

  // low bit of source i's field inside its priority word
  function automatic int prio_lsb(input int i);
    return 4 * (i % 8);
  endfunction
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
  import irqc_pkg::*;
#(
  parameter int NSRC = 21,
  parameter int NEXT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic [2*NEXT-1:0] trig_cfg,
  input  logic [NSRC-1:0]   edge_clr,
  output logic [NSRC-1:0]   pend
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g < NEXT) begin : g_ext
      logic  prev_q, latch_q, edge_evt;
      trig_e mode;
      assign mode = trig_e'(trig_cfg[2*g +: 2]);
      always_comb begin
        case (mode)
          TRIG_RISE: edge_evt = src[g] & ~prev_q;
          TRIG_FALL: edge_evt = ~src[g] & prev_q;
          default:   edge_evt = 1'b0;
        endcase
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q  <= 1'b0;
          latch_q <= 1'b0;
        end else begin
          prev_q  <= src[g];
          latch_q <= (latch_q & ~edge_clr[g]) | edge_evt;
        end
      end
      assign pend[g] = (mode == TRIG_RISE || mode == TRIG_FALL) ? latch_q : src[g];
    end else begin : g_lvl
      assign pend[g] = src[g];
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NSRC = 21,
  parameter int PW   = 3,
  parameter int IW   = 5
) (
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC*PW-1:0] prio,
  output logic               win_vld,
  output logic [IW-1:0]      win_idx,
  output logic [PW-1:0]      win_prio
);
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!win_vld || prio[i*PW +: PW] > win_prio)) begin
        win_vld  = 1'b1;
        win_idx  = IW'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest #(
  parameter int PW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PW-1:0]    take_prio,
  input  logic             pop,
  output logic [PW-1:0]    lvl,
  output logic             busy,
  output logic [(1<<PW)-1:0] insvc
);
  localparam int NLVL = 1 << PW;
  logic [NLVL-1:0] insvc_q, set_m, clr_m;

  always_comb begin
    lvl = '0;
    for (int k = 0; k < NLVL; k++) if (insvc_q[k]) lvl = PW'(k);
  end
  assign busy  = |insvc_q;
  assign set_m = take ? (NLVL'(1) << take_prio) : '0;
  assign clr_m = (pop && busy) ? (NLVL'(1) << lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= (insvc_q & ~clr_m) | set_m;
  end
  assign insvc = insvc_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 21,
  parameter int NEXT = 8,
  parameter int PW   = 3,
  parameter int AW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IW   = $clog2(NSRC);
  localparam int NLVL = 1 << PW;

  // decode
  logic       sel_n, sel_f;
  logic [7:0] off;
  assign sel_n = (bus_addr[AW-1:8] == '0);
  assign sel_f = (bus_addr[AW-1:8] == (AW-8)'(1));
  assign off   = bus_addr[7:0];

  logic wr_enset_n, wr_enclr_n, wr_enset_f, wr_enclr_f;
  logic take_n, take_f, pop_n, pop_f;
  assign wr_enset_n = bus_wr && sel_n && off == OFS_ENSET;
  assign wr_enclr_n = bus_wr && sel_n && off == OFS_ENCLR;
  assign wr_enset_f = bus_wr && sel_f && off == OFS_ENSET;
  assign wr_enclr_f = bus_wr && sel_f && off == OFS_ENCLR;
  assign pop_n      = bus_wr && sel_n && off == OFS_LVL;
  assign pop_f      = bus_wr && sel_f && off == OFS_LVL;

  // registers
  logic [NSRC-1:0]   en_n, en_f;
  logic [BUS_W-1:0]  base_q;
  logic [1:0]        nest_q;
  logic [2*NEXT-1:0] trig_q;
  logic [PW-1:0]     prio_q [NSRC];
  logic [NSRC*PW-1:0] prio_flat;

  for (genvar g = 0; g < NSRC; g++) begin : g_pf
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_n   <= '0;
      en_f   <= '0;
      base_q <= '0;
      nest_q <= '0;
      trig_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else begin
      if (wr_enset_n) en_n <= en_n | bus_wdata[NSRC-1:0];
      if (wr_enclr_n) en_n <= en_n & ~bus_wdata[NSRC-1:0];
      if (wr_enset_f) en_f <= en_f | bus_wdata[NSRC-1:0];
      if (wr_enclr_f) en_f <= en_f & ~bus_wdata[NSRC-1:0];
      if (bus_wr && sel_n) begin
        if (off == OFS_BASE) base_q <= {bus_wdata[BUS_W-1:2], 2'b00};
        if (off == OFS_NEST) nest_q <= bus_wdata[1:0];
        if (off == OFS_TRIG) trig_q <= bus_wdata[2*NEXT-1:0];
        for (int i = 0; i < NSRC; i++)
          if (off == prio_word_ofs(i)) prio_q[i] <= bus_wdata[prio_lsb(i) +: PW];
      end
    end
  end

  // capture
  logic [NSRC-1:0] edge_clr, pend, act_n, act_f;
  assign edge_clr = (bus_wr && sel_n && off == OFS_ECLR) ? bus_wdata[NSRC-1:0] : '0;

  irqc_capture #(.NSRC(NSRC), .NEXT(NEXT)) u_cap (
    .clk(clk), .rst_n(rst_n), .src(src_i), .trig_cfg(trig_q),
    .edge_clr(edge_clr), .pend(pend)
  );
  assign act_n = pend & en_n;
  assign act_f = pend & en_f;

  // arbitration
  logic          win_vld_n, win_vld_f;
  logic [IW-1:0] win_idx_n, win_idx_f;
  logic [PW-1:0] win_prio_n, win_prio_f;

  irqc_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb_n (
    .req(act_n), .prio(prio_flat),
    .win_vld(win_vld_n), .win_idx(win_idx_n), .win_prio(win_prio_n)
  );
  irqc_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb_f (
    .req(act_f), .prio(prio_flat),
    .win_vld(win_vld_f), .win_idx(win_idx_f), .win_prio(win_prio_f)
  );

  // nesting
  assign take_n = bus_rd && sel_n && off == OFS_VEC && win_vld_n;
  assign take_f = bus_rd && sel_f && off == OFS_VEC && win_vld_f;

  logic [PW-1:0]   lvl_n, lvl_f;
  logic            busy_n, busy_f;
  logic [NLVL-1:0] insvc_n, insvc_f;

  irqc_nest #(.PW(PW)) u_nest_n (
    .clk(clk), .rst_n(rst_n), .take(take_n), .take_prio(win_prio_n),
    .pop(pop_n), .lvl(lvl_n), .busy(busy_n), .insvc(insvc_n)
  );
  irqc_nest #(.PW(PW)) u_nest_f (
    .clk(clk), .rst_n(rst_n), .take(take_f), .take_prio(win_prio_f),
    .pop(pop_f), .lvl(lvl_f), .busy(busy_f), .insvc(insvc_f)
  );

  assign irq_o = win_vld_n && (!nest_q[0] || !busy_n || win_prio_n > lvl_n);
  assign fiq_o = win_vld_f && (!nest_q[1] || !busy_f || win_prio_f > lvl_f);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (sel_n) begin
      case (off)
        OFS_ACT:   bus_rdata[NSRC-1:0] = act_n;
        OFS_RAW:   bus_rdata[NSRC-1:0] = src_i;
        OFS_ENSET: bus_rdata[NSRC-1:0] = en_n;
        OFS_VEC:   bus_rdata = vec_addr(base_q, 8'(win_idx_n));
        OFS_BASE:  bus_rdata = base_q;
        OFS_LVL:   bus_rdata[PW:0] = {busy_n, lvl_n};
        OFS_NEST:  bus_rdata[1:0] = nest_q;
        OFS_TRIG:  bus_rdata[2*NEXT-1:0] = trig_q;
        default: begin
          for (int i = 0; i < NSRC; i++)
            if (off == prio_word_ofs(i)) bus_rdata[prio_lsb(i) +: PW] = prio_q[i];
        end
      endcase
    end else if (sel_f) begin
      case (off)
        OFS_ACT:   bus_rdata[NSRC-1:0] = act_f;
        OFS_RAW:   bus_rdata[NSRC-1:0] = src_i;
        OFS_ENSET: bus_rdata[NSRC-1:0] = en_f;
        OFS_VEC:   bus_rdata = vec_addr(base_q, 8'(win_idx_f));
        OFS_LVL:   bus_rdata[PW:0] = {busy_f, lvl_f};
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC = 21,
  parameter int PW   = 3,
  parameter int IW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   act_n,
  input logic [NSRC-1:0]   act_f,
  input logic              win_vld_n,
  input logic [IW-1:0]     win_idx_n,
  input logic [PW-1:0]     win_prio_n,
  input logic [PW-1:0]     lvl_n,
  input logic              busy_n,
  input logic              take_n,
  input logic              pop_n,
  input logic [(1<<PW)-1:0] insvc_n,
  input logic              wr_enset_n,
  input logic              wr_enclr_n,
  input logic [NSRC-1:0]   en_n,
  input logic [NSRC-1:0]   wsrc
);
  // R4: a normal request needs an active source
  a_r4_irq_has_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (act_n != '0));

  // R10: a fast request needs a fast-active source
  a_r10_fiq_has_active: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (act_f != '0));

  // R5: the winner is itself active
  a_r5_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_n |-> ((act_n >> win_idx_n) & NSRC'(1)) != '0);

  // R3: set and clear writes land on the written bits
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enset_n |=> (en_n & $past(wsrc)) == $past(wsrc));
  a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enclr_n |=> (en_n & $past(wsrc)) == '0);

  // R9: a claim raises the in-service level to at least the winner's priority
  a_r9_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    take_n |=> busy_n && (lvl_n >= $past(win_prio_n)));

  // R9: a release drops exactly one level
  a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n && !take_n && busy_n) |=> $countones(insvc_n) == $countones($past(insvc_n)) - 1);
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .act_n(act_n), .act_f(act_f), .win_vld_n(win_vld_n), .win_idx_n(win_idx_n),
  .win_prio_n(win_prio_n), .lvl_n(lvl_n), .busy_n(busy_n), .take_n(take_n),
  .pop_n(pop_n), .insvc_n(insvc_n), .wr_enset_n(wr_enset_n),
  .wr_enclr_n(wr_enclr_n), .en_n(en_n), .wsrc(bus_wdata[NSRC-1:0])
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_P = 10;
  localparam int NS = 21;
  localparam logic [20:0] ALL = 21'h1FFFFF;
  localparam logic [31:0] BASE = 32'h0000_1000;

  // arbitration table, priority of source i is i%8
  localparam int NROW = 7;
  localparam logic [20:0] T_SRC [NROW] = '{21'h000028, 21'h008080, 21'h108000,
                                           21'h000000, 21'h010100, 21'h101000, 21'h000002};
  localparam logic [20:0] T_EN  [NROW] = '{ALL, ALL, 21'h1F7FFF, ALL, ALL, ALL, 21'h0};
  localparam logic        T_VLD [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          T_IDX [NROW] = '{5, 7, 20, 0, 8, 12, 0};

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [NS-1:0] src = '0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irqc_top dut (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
    #1;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
    #1;
  endtask

  task automatic rchk(input string r, input logic [9:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    chk(r, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    rchk("R1 en", 10'h008, 0);
    rchk("R1 base", 10'h014, 0);
    rchk("R1 prio", 10'h020, 0);
    rchk("R1 nest", 10'h030, 0);
    rchk("R1 lvl", 10'h018, 0);
    rchk("R1 fast en", 10'h108, 0);

    // R2 raw view with nothing enabled
    src = 21'h155555; step(1);
    rchk("R2 raw", 10'h004, 32'h155555);
    rchk("R2 raw fast", 10'h104, 32'h155555);
    rchk("R4 act none enabled", 10'h000, 0);
    chk("R4 irq low", 32'(irq_o), 0);
    src = '0;

    // R3 set / clear
    wr(10'h008, 32'h0F);
    wr(10'h008, 32'h30);
    rchk("R3 set", 10'h008, 32'h3F);
    wr(10'h00C, 32'h05);
    rchk("R3 clear", 10'h008, 32'h3A);
    rchk("R3 fast untouched", 10'h108, 0);
    wr(10'h00C, 32'hFFFFFFFF);

    // R6 priority layout
    wr(10'h024, 32'hFFFFFFFF);
    rchk("R6 field mask", 10'h024, 32'h77777777);
    wr(10'h020, 32'h76543210);
    wr(10'h024, 32'h76543210);
    wr(10'h028, 32'hFFF43210);
    rchk("R6 word0", 10'h020, 32'h76543210);
    rchk("R6 word2 tail", 10'h028, 32'h00043210);

    // R5 base alignment
    wr(10'h014, BASE | 32'h3);
    rchk("R5 base", 10'h014, BASE);

    // R4 R5 arbitration table
    for (int r = 0; r < NROW; r++) begin
      logic [31:0] v;
      wr(10'h00C, 32'hFFFFFFFF);
      wr(10'h008, 32'(T_EN[r]));
      src = T_SRC[r]; step(1);
      chk($sformatf("R4 row%0d irq", r), 32'(irq_o), 32'(T_VLD[r]));
      rchk($sformatf("R4 row%0d act", r), 10'h000, 32'(T_SRC[r] & T_EN[r]));
      rd(10'h010, v);
      chk($sformatf("R5 row%0d vec", r), v, T_VLD[r] ? BASE + 32'(4*T_IDX[r]) : BASE);
    end
    src = '0;
    for (int k = 0; k < 8; k++) wr(10'h018, 0);
    rchk("R9 drained", 10'h018, 0);

    // R7 R8 edge capture: src2 rising, src3 falling
    wr(10'h00C, 32'hFFFFFFFF);
    wr(10'h008, 32'h0C);
    wr(10'h034, 32'h90);
    src[2] = 1; step(2);
    rchk("R7 rise latched", 10'h000, 32'h4);
    src[2] = 0; step(1);
    rchk("R7 rise held", 10'h000, 32'h4);
    wr(10'h038, 32'h4);
    rchk("R8 clear", 10'h000, 0);
    src[2] = 1; step(2);
    wr(10'h038, 32'h4);
    step(1);
    rchk("R8 no relatch on level", 10'h000, 0);
    src[2] = 0;
    src[3] = 1; step(2);
    rchk("R7 fall ignores rise", 10'h000, 0);
    src[3] = 0; step(2);
    rchk("R7 fall latched", 10'h000, 32'h8);
    wr(10'h038, 32'h8);
    wr(10'h034, 32'h0);
    src[2] = 1; step(1);
    rchk("R7 level follows", 10'h000, 32'h4);
    src[2] = 0; step(1);
    rchk("R7 level drops", 10'h000, 0);

    // R9 nesting on the normal path
    wr(10'h00C, 32'hFFFFFFFF);
    wr(10'h008, 32'h28);
    wr(10'h030, 32'h1);
    src[3] = 1; step(1);
    chk("R9 first irq", 32'(irq_o), 1);
    rchk("R9 claim3 vec", 10'h010, BASE + 32'd12);
    rchk("R9 lvl3", 10'h018, 32'hB);
    chk("R9 masked same", 32'(irq_o), 0);
    src[5] = 1; step(1);
    chk("R9 higher passes", 32'(irq_o), 1);
    rchk("R9 claim5 vec", 10'h010, BASE + 32'd20);
    rchk("R9 lvl5", 10'h018, 32'hD);
    chk("R9 masked at 5", 32'(irq_o), 0);
    wr(10'h018, 0);
    rchk("R9 restored 3", 10'h018, 32'hB);
    chk("R9 irq after release", 32'(irq_o), 1);
    rchk("R9 reclaim5", 10'h010, BASE + 32'd20);
    chk("R9 masked again", 32'(irq_o), 0);
    wr(10'h030, 32'h0);
    chk("R9 nesting off", 32'(irq_o), 1);
    wr(10'h018, 0);
    wr(10'h018, 0);
    rchk("R9 empty", 10'h018, 0);
    src = '0;

    // R10 fast path
    wr(10'h00C, 32'hFFFFFFFF);
    wr(10'h108, 32'h50);
    src[4] = 1; step(1);
    chk("R10 fiq", 32'(fiq_o), 1);
    chk("R10 irq quiet", 32'(irq_o), 0);
    rchk("R10 fast act", 10'h100, 32'h10);
    rchk("R10 fast vec", 10'h110, BASE + 32'd16);
    rchk("R10 fast lvl", 10'h118, 32'hC);
    rchk("R10 normal lvl", 10'h018, 0);
    wr(10'h10C, 32'h10);
    chk("R10 fiq cleared", 32'(fiq_o), 0);
    rchk("R10 fast en", 10'h108, 32'h40);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule